// File: doc/BRIEF.md
# Tile Unpack Front End

This block is the control and output side of a streaming tile decompressor. It watches processor writes to the configuration registers of eight DMA channels and to a pair of enable registers. When the second enable register is written, it selects a channel set up for decompression. It then arms itself on that channel's source address and loads that channel's transfer count. From then on, a ROM read at exactly that address is served by the block rather than by the ROM.

Once armed, the block fetches the compressed stream from ROM through its own port and takes bits from it MSB first. It parses a four-bit header that gives a colour depth and a context selection. It then drives an external bit decoder one plane at a time and assembles the decoded bits into a 16-, 32- or 64-byte tile buffer. The buffer is filled in planar or chunky order. Each read at the trigger address returns the next buffer byte, and a new block is decoded each time the buffer position wraps to zero. When the count runs out, the block disarms.

States: `ST_OFF` (disarmed), `ST_HEAD` (taking the four header bits), `ST_READY` (armed and idle), `ST_FILL` (decoding a block), `ST_EMIT` (returning one byte). Transitions: a write to the second enable register goes to `ST_HEAD` from any state when a channel qualifies, and to `ST_OFF` when none does. `ST_HEAD` goes to `ST_READY` after the fourth header bit. `ST_READY` goes to `ST_FILL` on a request while the position is 0, and to `ST_EMIT` on a request at any other position. `ST_FILL` goes to `ST_EMIT` when the last bit of the block is acknowledged. `ST_EMIT` goes to `ST_OFF` on the final counted byte and to `ST_READY` otherwise.

Top module: `tile_unpack_front`

## Requirements
- R1: The write-side register map decodes the low 16 address bits. Channel c register r sits at 0x4300 + 16c + r, where r=0 is control, r=2,3,4 are source address bytes (low, mid, high) and r=5,6 are count bytes (low, high). The enable registers are at 0x4800 and 0x4801. A write to 0x4801 always disarms first. It then arms on the lowest-numbered channel whose bit is set in both enable values and whose control byte has bit 7 clear and bit 3 set.
- R2: While armed, `rd_hit` is high only for a read (`rd_en`) whose 24-bit address equals the chosen channel's source address. Reads at any other address, and every read while disarmed, leave `rd_hit` low.
- R3: The compressed stream is fetched from ROM starting at the trigger address, one byte per `rom_req`/`rom_ack` exchange, with `rom_addr` rising by one per fetched byte and held steady while a request waits. Bits are consumed from each byte most significant first.
- R4: The first two stream bits form the depth code (first bit is the more significant). The next two form the context selection, which is presented on `dec_ctx`. `dec_start` pulses for one cycle as the fourth header bit is taken.
- R5: Depth code 0 gives 2 planes and a 16-byte block, code 2 gives 4 planes and 32 bytes, code 1 gives 8 planes and 64 bytes (all planar), and code 3 gives 8 planes and 64 bytes in chunky order.
- R6: Planar order: for each plane pair (2q, 2q+1), each row y in 0..7 and each pixel x in 0..7, one bit is decoded for plane 2q and then one for plane 2q+1. These land at bit 7-x of bytes 16q+2y and 16q+2y+1 respectively.
- R7: Chunky order: each output byte i in 0..63 is built from eight decoded bits for planes 0 through 7 in turn, with plane k's bit at bit position k.
- R8: Each hit returns the next buffer byte in offset order with a one-cycle `rd_valid`, and `rd_valid` is never high on two cycles in a row. A block is decoded before the byte at position 0 is returned. `busy` is high while a hit waits for service or a block is being decoded.
- R9: Each returned byte decrements the count. After the counted number of bytes the block disarms, so a further read at the trigger address no longer hits. A count of 0 is treated as 65536.
- R10: `dec_req` stays high with a steady `dec_plane` until `dec_ack`. `strm_ok` is offered to the decoder only while a block is being decoded. A write that arms nothing leaves `busy`, `dec_req` and `rd_valid` low on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | Processor write strobe being snooped |
| cpu_addr | input | 24 | Processor write address |
| cpu_wdata | input | 8 | Processor write data |
| rd_en | input | 1 | ROM-side read strobe |
| rd_addr | input | 24 | ROM-side read address |
| rd_hit | output | 1 | Read is claimed by this block |
| busy | output | 1 | Claimed read is waiting on decode |
| rd_valid | output | 1 | Returned byte is valid this cycle |
| rd_data | output | 8 | Returned byte |
| rom_req | output | 1 | Stream byte fetch request |
| rom_addr | output | 24 | Stream byte fetch address |
| rom_ack | input | 1 | Fetch data valid |
| rom_data | input | 8 | Fetched stream byte |
| dec_start | output | 1 | Decoder state restart pulse |
| dec_ctx | output | 2 | Context selection from header |
| dec_req | output | 1 | Request one decoded bit |
| dec_plane | output | 3 | Plane of the requested bit |
| dec_ack | input | 1 | Decoded bit valid |
| dec_bit | input | 1 | Decoded bit |
| strm_ok | output | 1 | A raw stream bit is available |
| strm_bit | output | 1 | Current raw stream bit |
| strm_take | input | 1 | Decoder consumes the raw stream bit |

## Verification
The hardest conditions to reach are the channel scan corner cases and the block-boundary wrap. Reaching them needs several channels that each fail a different arming condition while one channel qualifies, and runs long enough that the buffer position wraps in every depth. The stimulus sets up a crowd of near-miss channels before each arming. It writes a chosen header nibble into a pattern-filled ROM, then reads two full blocks plus a few bytes in each mode. The bench decoder passes raw stream bits straight through and checks each requested plane, so every output byte can be predicted arithmetically from ROM contents and the order rules.

// File: rtl/tup_pkg.sv
package tup_pkg;
    typedef enum logic [2:0] {
        ST_OFF,
        ST_HEAD,
        ST_READY,
        ST_FILL,
        ST_EMIT
    } tup_state_e;

    localparam int TUP_AW = 24;
endpackage

// File: rtl/tup_snoop.sv
module tup_snoop #(
    parameter int          CH_N     = 8,
    parameter logic [7:0]  DMA_PAGE = 8'h43,
    parameter logic [15:0] ENA_ADDR = 16'h4800
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr,
    input  logic [tup_pkg::TUP_AW-1:0] addr,
    input  logic [7:0]                 wdata,
    output logic                       reload,
    output logic                       arm,
    output logic [tup_pkg::TUP_AW-1:0] trig,
    output logic [16:0]                len
);
    localparam int CW = (CH_N > 1) ? $clog2(CH_N) : 1;

    logic [7:0]                 ctrl_q [CH_N];
    logic [tup_pkg::TUP_AW-1:0] src_q  [CH_N];
    logic [15:0]                cnt_q  [CH_N];
    logic [CH_N-1:0]            en0_q;
    logic [CW-1:0]              wch;
    logic                       ch_wr;
    logic [CW-1:0]              sel;
    logic                       found;

    assign wch   = addr[4 +: CW];
    assign ch_wr = wr && (addr[15:8] == DMA_PAGE) && !addr[7] && (32'(wch) < CH_N);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en0_q <= '0;
            for (int i = 0; i < CH_N; i++) begin
                ctrl_q[i] <= 8'hFF;
                src_q[i]  <= '1;
                cnt_q[i]  <= 16'hFFFF;
            end
        end else begin
            if (wr && addr[15:0] == ENA_ADDR)
                en0_q <= wdata[CH_N-1:0];
            if (ch_wr) begin
                case (addr[3:0])
                    4'h0: ctrl_q[wch]        <= wdata;
                    4'h2: src_q[wch][7:0]    <= wdata;
                    4'h3: src_q[wch][15:8]   <= wdata;
                    4'h4: src_q[wch][23:16]  <= wdata;
                    4'h5: cnt_q[wch][7:0]    <= wdata;
                    4'h6: cnt_q[wch][15:8]   <= wdata;
                    default: ;
                endcase
            end
        end
    end

    // Descending scan: the lowest qualifying channel is written last and wins.
    always_comb begin
        found = 1'b0;
        sel   = '0;
        for (int i = CH_N - 1; i >= 0; i--) begin
            if (en0_q[i] && wdata[i] && ((ctrl_q[i] & 8'h88) == 8'h08)) begin
                found = 1'b1;
                sel   = CW'(i);
            end
        end
    end

    assign reload = wr && (addr[15:0] == ENA_ADDR + 16'd1);
    assign arm    = reload && found;
    assign trig   = src_q[sel];
    assign len    = (cnt_q[sel] == 16'd0) ? 17'h10000 : {1'b0, cnt_q[sel]};
endmodule

// File: rtl/tup_bitrd.sv
module tup_bitrd (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [tup_pkg::TUP_AW-1:0] start_addr,
    input  logic                       run,
    input  logic                       take,
    output logic                       rom_req,
    output logic [tup_pkg::TUP_AW-1:0] rom_addr,
    input  logic                       rom_ack,
    input  logic [7:0]                 rom_data,
    output logic                       ok,
    output logic                       bit_o
);
    logic [7:0]                 sh_q;
    logic [3:0]                 left_q;
    logic [tup_pkg::TUP_AW-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q   <= '0;
            left_q <= '0;
            addr_q <= '0;
        end else if (start) begin
            sh_q   <= '0;
            left_q <= '0;
            addr_q <= start_addr;
        end else if (rom_req && rom_ack) begin
            sh_q   <= rom_data;
            left_q <= 4'd8;
            addr_q <= addr_q + 1'b1;
        end else if (take && left_q != 4'd0) begin
            sh_q   <= {sh_q[6:0], 1'b0};
            left_q <= left_q - 1'b1;
        end
    end

    assign rom_req  = run && (left_q == 4'd0);
    assign rom_addr = addr_q;
    assign ok       = (left_q != 4'd0);
    assign bit_o    = sh_q[7];
endmodule

// File: rtl/tup_tilebuf.sv
module tup_tilebuf #(
    parameter int BYTES = 64,
    localparam int PW = $clog2(BYTES),
    localparam int SW = PW + 3
) (
    input  logic          clk,
    input  logic          wr,
    input  logic [SW-1:0] step,
    input  logic          chunky,
    input  logic          bit_i,
    input  logic [PW-1:0] pos,
    output logic [7:0]    byte_o
);
    logic [7:0]    tile_q [BYTES];
    logic [PW-1:0] idx;
    logic [2:0]    bpos;

    // Planar step = {pair, row, pixel, odd}; chunky step = {byte, plane}.
    always_comb begin
        if (chunky) begin
            idx  = step[SW-1:3];
            bpos = step[2:0];
        end else begin
            idx  = {step[SW-1:4], step[0]};
            bpos = ~step[3:1];
        end
    end

    always_ff @(posedge clk) begin
        if (wr)
            tile_q[idx][bpos] <= bit_i;
    end

    assign byte_o = tile_q[pos];
endmodule

// File: rtl/tile_unpack_front.sv
module tile_unpack_front #(
    parameter int          CH_N      = 8,
    parameter logic [7:0]  DMA_PAGE  = 8'h43,
    parameter logic [15:0] ENA_ADDR  = 16'h4800,
    parameter int          BUF_BYTES = 64,
    localparam int PW = $clog2(BUF_BYTES),
    localparam int SW = PW + 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cpu_wr,
    input  logic [23:0] cpu_addr,
    input  logic [7:0]  cpu_wdata,
    input  logic        rd_en,
    input  logic [23:0] rd_addr,
    output logic        rd_hit,
    output logic        busy,
    output logic        rd_valid,
    output logic [7:0]  rd_data,
    output logic        rom_req,
    output logic [23:0] rom_addr,
    input  logic        rom_ack,
    input  logic [7:0]  rom_data,
    output logic        dec_start,
    output logic [1:0]  dec_ctx,
    output logic        dec_req,
    output logic [2:0]  dec_plane,
    input  logic        dec_ack,
    input  logic        dec_bit,
    output logic        strm_ok,
    input  logic        strm_take,
    output logic        strm_bit
);
    import tup_pkg::*;

    tup_state_e     state_q, state_d;
    logic           reload, arm;
    logic [23:0]    snp_trig;
    logic [16:0]    snp_len;
    logic [23:0]    trig_q;
    logic [16:0]    left_q;
    logic [PW-1:0]  pos_q, mask;
    logic [SW-1:0]  step_q, last;
    logic [1:0]     depth_q, ctx_q, hcnt_q;
    logic [2:0]     hsh_q;
    logic           pend_q, req, chunky;
    logic           rdr_ok, rdr_bit, rdr_take, hdr_take;
    logic [7:0]     tile_byte;

    tup_snoop #(.CH_N(CH_N), .DMA_PAGE(DMA_PAGE), .ENA_ADDR(ENA_ADDR)) snoop_i (
        .clk(clk), .rst_n(rst_n), .wr(cpu_wr), .addr(cpu_addr), .wdata(cpu_wdata),
        .reload(reload), .arm(arm), .trig(snp_trig), .len(snp_len)
    );

    tup_bitrd bitrd_i (
        .clk(clk), .rst_n(rst_n), .start(arm), .start_addr(snp_trig),
        .run(state_q != ST_OFF), .take(rdr_take),
        .rom_req(rom_req), .rom_addr(rom_addr), .rom_ack(rom_ack), .rom_data(rom_data),
        .ok(rdr_ok), .bit_o(rdr_bit)
    );

    tup_tilebuf #(.BYTES(BUF_BYTES)) tile_i (
        .clk(clk), .wr(state_q == ST_FILL && dec_ack), .step(step_q), .chunky(chunky),
        .bit_i(dec_bit), .pos(pos_q), .byte_o(tile_byte)
    );

    // Depth code decode: block size mask and last step of a block.
    always_comb begin
        chunky = (depth_q == 2'd3);
        unique case (depth_q)
            2'd0:    begin mask = PW'(BUF_BYTES / 4 - 1); last = SW'(BUF_BYTES * 2 - 1); end
            2'd2:    begin mask = PW'(BUF_BYTES / 2 - 1); last = SW'(BUF_BYTES * 4 - 1); end
            default: begin mask = PW'(BUF_BYTES - 1);     last = SW'(BUF_BYTES * 8 - 1); end
        endcase
    end

    assign rd_hit   = rd_en && (state_q != ST_OFF) && (rd_addr == trig_q);
    assign req      = pend_q || rd_hit;
    assign hdr_take = (state_q == ST_HEAD) && rdr_ok;
    assign rdr_take = hdr_take || (state_q == ST_FILL && strm_take);

    always_comb begin
        state_d = state_q;
        if (reload) begin
            state_d = arm ? ST_HEAD : ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF:   state_d = ST_OFF;
                ST_HEAD:  if (hdr_take && hcnt_q == 2'd3) state_d = ST_READY;
                ST_READY: if (req) state_d = (pos_q == '0) ? ST_FILL : ST_EMIT;
                ST_FILL:  if (dec_ack && step_q == last) state_d = ST_EMIT;
                ST_EMIT:  state_d = (left_q == 17'd1) ? ST_OFF : ST_READY;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        rd_valid  = (state_q == ST_EMIT);
        rd_data   = tile_byte;
        busy      = pend_q || (state_q == ST_FILL);
        dec_req   = (state_q == ST_FILL);
        dec_plane = chunky ? step_q[2:0] : {step_q[SW-1:SW-2], step_q[0]};
        dec_start = hdr_take && (hcnt_q == 2'd3);
        dec_ctx   = dec_start ? {hsh_q[0], rdr_bit} : ctx_q;
        strm_ok   = rdr_ok && (state_q == ST_FILL);
        strm_bit  = rdr_bit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q  <= 1'b0;
            trig_q  <= '0;
            left_q  <= '0;
            pos_q   <= '0;
            step_q  <= '0;
            depth_q <= '0;
            ctx_q   <= '0;
            hcnt_q  <= '0;
            hsh_q   <= '0;
        end else if (reload) begin
            pend_q <= 1'b0;
            if (arm) begin
                trig_q <= snp_trig;
                left_q <= snp_len;
                pos_q  <= '0;
                hcnt_q <= '0;
            end
        end else begin
            if (state_q == ST_READY) pend_q <= 1'b0;
            else if (rd_hit)         pend_q <= 1'b1;
            if (hdr_take) begin
                hsh_q  <= {hsh_q[1:0], rdr_bit};
                hcnt_q <= hcnt_q + 1'b1;
                if (hcnt_q == 2'd3) begin
                    depth_q <= hsh_q[2:1];
                    ctx_q   <= {hsh_q[0], rdr_bit};
                end
            end
            if (state_q == ST_READY && req && pos_q == '0) step_q <= '0;
            if (state_q == ST_FILL && dec_ack)             step_q <= step_q + 1'b1;
            if (state_q == ST_EMIT) begin
                pos_q  <= (pos_q + 1'b1) & mask;
                left_q <= left_q - 1'b1;
            end
        end
    end
endmodule

// File: rtl/tile_unpack_front_chk.sv
module tile_unpack_front_chk #(
    parameter logic [15:0] ENA_ADDR = 16'h4800
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cpu_wr,
    input logic [23:0] cpu_addr,
    input logic [7:0]  cpu_wdata,
    input logic        busy,
    input logic        rd_valid,
    input logic        rom_req,
    input logic [23:0] rom_addr,
    input logic        rom_ack,
    input logic        dec_req,
    input logic [2:0]  dec_plane,
    input logic        dec_ack
);
    assert_disarm_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr[15:0] == ENA_ADDR + 16'd1 && cpu_wdata == 8'h00)
        |=> (!busy && !dec_req && !rd_valid));

    assert_fetch_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_req && !rom_ack && !cpu_wr) |=> (rom_req && $stable(rom_addr)));

    assert_fetch_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_req && rom_ack && !cpu_wr) |=> (rom_addr == $past(rom_addr) + 24'd1));

    assert_single_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    assert_decode_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dec_req |-> busy);

    assert_plane_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_req && !dec_ack && !cpu_wr) |=> (dec_req && $stable(dec_plane)));
endmodule

bind tile_unpack_front tile_unpack_front_chk #(.ENA_ADDR(ENA_ADDR)) chk_i (.*);

// File: tb/tile_unpack_front_tb.sv
module tile_unpack_front_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [23:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        rd_en = 1'b0;
    logic [23:0] rd_addr = '0;
    logic        rd_hit, busy, rd_valid;
    logic [7:0]  rd_data;
    logic        rom_req;
    logic [23:0] rom_addr;
    logic        rom_ack = 1'b0;
    logic [7:0]  rom_data = '0;
    logic        dec_start, dec_req, strm_ok, strm_bit;
    logic [1:0]  dec_ctx;
    logic [2:0]  dec_plane;
    logic        dec_ack = 1'b0;
    logic        dec_bit = 1'b0;
    logic        strm_take = 1'b0;

    int checks = 0;
    int fails = 0;
    int plane_err = 0;
    int dstep = 0;
    int dph = 0;
    logic dcap = 1'b0;
    int cur_depth = 0;
    logic [7:0] mem [4096];

    always #(CLK_PERIOD / 2) clk = ~clk;

    tile_unpack_front dut_i (.*);

    // ROM model: one-cycle acknowledge
    always @(negedge clk) begin
        if (rom_ack) rom_ack <= 1'b0;
        else if (rom_req) begin
            rom_ack  <= 1'b1;
            rom_data <= mem[rom_addr[11:0]];
        end
    end

    function automatic int blk_bytes(input int d);
        return (d == 0) ? 16 : (d == 2) ? 32 : 64;
    endfunction

    // Pass-through decoder model that also checks the requested plane order
    always @(negedge clk) begin
        if (dec_start) dstep <= 0;
        case (dph)
            0: if (dec_req && strm_ok) begin
                int j, exp_pl;
                j = dstep % (blk_bytes(cur_depth) * 8);
                exp_pl = (cur_depth == 3) ? (j % 8) : ((j / 128) * 2 + (j % 2));
                if (int'(dec_plane) != exp_pl) plane_err <= plane_err + 1;
                strm_take <= 1'b1;
                dcap <= strm_bit;
                dph <= 1;
            end
            1: begin
                strm_take <= 1'b0;
                dec_ack <= 1'b1;
                dec_bit <= dcap;
                dstep <= dstep + 1;
                dph <= 2;
            end
            default: begin
                dec_ack <= 1'b0;
                dph <= 0;
            end
        endcase
    end

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_wr = 1'b1; cpu_addr = {8'h00, a}; cpu_wdata = d;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic set_chan(input int ch, input logic [7:0] ctl, input logic [23:0] src, input logic [15:0] n);
        logic [15:0] b;
        b = 16'h4300 + 16'(ch * 16);
        wr(b + 16'd0, ctl);
        wr(b + 16'd2, src[7:0]);
        wr(b + 16'd3, src[15:8]);
        wr(b + 16'd4, src[23:16]);
        wr(b + 16'd5, n[7:0]);
        wr(b + 16'd6, n[15:8]);
    endtask

    task automatic do_read(input logic [23:0] a, output logic hit, output logic [7:0] d, output logic bsy);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        #1 hit = rd_hit;
        @(negedge clk);
        rd_en = 1'b0;
        bsy = busy;
        d = 8'h00;
        if (hit) begin
            int w = 0;
            while (!rd_valid && w < 20000) begin
                @(negedge clk);
                bsy |= busy;
                w++;
            end
            d = rd_data;
        end
    endtask

    function automatic logic sbit(input int base, input int j);
        int g;
        g = j + 4;
        return mem[(base + g / 8) & 12'hFFF][7 - (g % 8)];
    endfunction

    function automatic logic [7:0] exp_byte(input int base, input int d, input int n);
        int nb, k, b, s;
        logic [7:0] v;
        nb = blk_bytes(d);
        k = n / nb;
        b = n % nb;
        v = '0;
        for (int i = 0; i < 8; i++) begin
            if (d == 3) begin
                s = b * 8 + i;
                v[i] = sbit(base, k * 512 + s);
            end else begin
                s = (b / 16) * 128 + ((b % 16) / 2) * 16 + i * 2 + (b % 2);
                v[7 - i] = sbit(base, k * nb * 8 + s);
            end
        end
        return v;
    endfunction

    task automatic run_mode(input int d, input int ctx, input logic [23:0] trig, input int n, input int reads);
        logic hit, bsy;
        logic [7:0] v;
        int bad;
        mem[trig[11:0]] = {d[1:0], ctx[1:0], mem[trig[11:0]][3:0]};
        cur_depth = d;
        plane_err = 0;
        set_chan(0, 8'h08, trig, n[15:0]);
        wr(16'h4800, 8'h01);
        wr(16'h4801, 8'h01);
        bad = 0;
        for (int i = 0; i < reads; i++) begin
            do_read(trig, hit, v, bsy);
            if (i == 0) begin
                chk(bsy, "R8 busy during first block", bsy, 1);
                chk(dec_ctx == ctx[1:0], "R4 header context", dec_ctx, ctx);
            end
            if (!hit || v != exp_byte(trig[11:0], d, i)) begin
                if (bad == 0)
                    chk(1'b0, (d == 3) ? "R7 chunky byte" : "R6 planar byte", v, exp_byte(trig[11:0], d, i));
                bad++;
            end
        end
        chk(bad == 0, "R5 all bytes of depth mode", bad, 0);
        chk(plane_err == 0, "R10 decoder plane sequence", plane_err, 0);
    endtask

    initial begin
        logic hit, bsy;
        logic [7:0] v;
        for (int i = 0; i < 4096; i++) mem[i] = 8'((i * 73) + ((i >> 3) * 5) + 29);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Reset state
        do_read(24'h000000, hit, v, bsy);
        chk(!hit, "R2 no hit after reset", hit, 0);
        chk(!busy && !dec_req && !rom_req, "R2 idle after reset", {busy, dec_req, rom_req}, 0);

        // Channel scan with near-miss channels
        set_chan(1, 8'h08, 24'hC00110, 16'd4);
        set_chan(3, 8'h88, 24'hC00130, 16'd4);
        set_chan(4, 8'h09, 24'hC00140, 16'd4);
        set_chan(6, 8'h08, 24'hC00160, 16'd4);
        set_chan(2, 8'h08, 24'hC00120, 16'd4);
        wr(16'h4800, 8'h5A);
        wr(16'h4801, 8'h58);
        do_read(24'hC00160, hit, v, bsy);
        chk(!hit, "R1 higher channel not chosen", hit, 0);
        do_read(24'hC00110, hit, v, bsy);
        chk(!hit, "R1 channel missing second enable", hit, 0);
        do_read(24'hC00130, hit, v, bsy);
        chk(!hit, "R1 control bit 7 set rejected", hit, 0);
        do_read(24'hC00141, hit, v, bsy);
        chk(!hit, "R2 neighbour address misses", hit, 0);
        do_read(24'hC00140, hit, v, bsy);
        chk(hit, "R1 lowest qualifying channel armed", hit, 1);

        // Disarm by enable write with no qualifying channel
        wr(16'h4801, 8'h00);
        do_read(24'hC00140, hit, v, bsy);
        chk(!hit, "R1 disarm on empty enable", hit, 0);
        chk(!busy, "R10 quiet after disarm", busy, 0);

        // Each depth mode, two blocks and a few bytes, then count end
        run_mode(0, 1, 24'hC00410, 35, 35);
        do_read(24'hC00410, hit, v, bsy);
        chk(!hit, "R9 disarm after count depth 0", hit, 0);
        run_mode(2, 2, 24'hC00800, 67, 67);
        do_read(24'hC00800, hit, v, bsy);
        chk(!hit, "R9 disarm after count depth 2", hit, 0);
        run_mode(1, 3, 24'hC00A05, 131, 131);
        do_read(24'hC00A05, hit, v, bsy);
        chk(!hit, "R9 disarm after count depth 1", hit, 0);
        run_mode(3, 0, 24'hC00C00, 131, 131);
        do_read(24'hC00C00, hit, v, bsy);
        chk(!hit, "R9 disarm after count depth 3", hit, 0);

        // Count of zero keeps running past small counts
        run_mode(0, 3, 24'hC00200, 0, 40);
        do_read(24'hC00200, hit, v, bsy);
        chk(hit, "R9 zero count still armed", hit, 1);
        chk(v == exp_byte(12'h200, 0, 40), "R3 stream continues", v, exp_byte(12'h200, 0, 40));

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R8 watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule